// File: doc/BRIEF.md
# Embedded DRAM Test Port Controller

This block gives a tester access to several embedded DRAM macros through a small set of pins. A test-mode enable, a 5-bit command and an 18-bit shared bus are sampled on every rising clock edge. The shared bus carries different fields depending on the command: a row address, a column address, write data, or a macro index. The block joins the row half and the column half into one full address. It then sends a single-cycle operation to the selected macro over an internal bus. It also steers that macro's 9-bit read word, 8 data bits plus parity, onto one output.

A select command picks which macro is active, and only that macro gets operations or drives the output. A burn-in command passes the macro bus to an on-chip pattern generator. From then on the external commands are ignored, except the one that ends burn-in. Leaving test mode makes the macro bus idle, ends burn-in, and discards any half-sent address.

Top module: `edram_test_port`

## Requirements
- R1: After reset the macro enables are all 0, the operation code is idle (0), the generator enable is low, macro 0 is selected, and the read output is 0.
- R2: While the test-mode input is low, no command has any effect: the enables stay 0, the read output is 0, and the selected macro does not change.
- R3: Command 0x01 latches bus bits [11:0] as the row. Command 0x03 (read) or 0x04 (write) takes bus bits [9:0] as the column. The block then issues one operation with the 22-bit address {row, column} and op code read=1 or write=2. The operation appears on the second rising edge after the column is sampled and lasts exactly one cycle.
- R4: A read or write is ignored when no row has been latched since the last operation. Each latched row is used by at most one operation.
- R5: Command 0x02 latches bus bits [7:0] as write data. The next write presents that value on the write-data output.
- R6: Command 0x08 selects the macro whose index is in bus bits [1:0]. An index at or above the macro count is ignored.
- R7: An issued operation raises only the enable bit of the selected macro.
- R8: The read output carries the selected macro's 8 data bits in bits [7:0]. Bit 8 is that macro's own parity bit when the macro supplies parity (macros 0 and 2 by default). Otherwise bit 8 is even parity computed from the data bits.
- R9: Command 0x10 enters burn-in and raises the generator enable. The macro bus then follows the generator inputs one edge later, and the selected macro is enabled whenever the generator input is valid. All external commands except 0x11 are ignored.
- R10: Command 0x11 leaves burn-in. Dropping test mode also leaves burn-in and discards a latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tm_en_i | input | 1 | Test-mode enable pin |
| cmd_i | input | 5 | Command pins |
| bus_i | input | 18 | Shared row/column/data/index pins |
| mac_rdata_i | input | 27 | Read words of all macros, 9 bits each, macro 0 lowest |
| pg_valid_i | input | 1 | Generator operation valid |
| pg_op_i | input | 2 | Generator operation code |
| pg_addr_i | input | 22 | Generator address |
| pg_wdata_i | input | 8 | Generator write data |
| dout_o | output | 9 | Selected read word with parity |
| mac_en_o | output | 3 | One enable per macro |
| mac_op_o | output | 2 | Operation code: 0 idle, 1 read, 2 write |
| mac_addr_o | output | 22 | Full operation address |
| mac_wdata_o | output | 8 | Write data |
| pg_en_o | output | 1 | Burn-in active, generator may run |

## Verification
The assertions assume that the generator inputs only matter while burn-in is active. They also assume that a generator operation marked valid carries a read or write code. The stimulus drives the generator inputs only inside the burn-in scenario and keeps valid low everywhere else. The assertions also assume that pins change away from the sampling edge. The bench therefore changes every input on the falling clock edge and reads outputs on the following falling edge.

// File: rtl/edram_tp_pkg.sv
package edram_tp_pkg;
  typedef enum logic [4:0] {
    CMD_NOP    = 5'h00,
    CMD_ROW    = 5'h01,
    CMD_WDAT   = 5'h02,
    CMD_RD     = 5'h03,
    CMD_WR     = 5'h04,
    CMD_SEL    = 5'h08,
    CMD_BI_ON  = 5'h10,
    CMD_BI_OFF = 5'h11
  } tp_cmd_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mac_op_e;
endpackage

// File: rtl/edram_tp_capture.sv
module edram_tp_capture #(
  parameter int CMD_W = 5,
  parameter int BUS_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tm_en_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             tm_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [BUS_W-1:0] bus_o
);
  // pins are sampled once here; all decode works from these flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_o  <= 1'b0;
      cmd_o <= '0;
      bus_o <= '0;
    end else begin
      tm_o  <= tm_en_i;
      cmd_o <= cmd_i;
      bus_o <= bus_i;
    end
  end
endmodule

// File: rtl/edram_tp_decode.sv
module edram_tp_decode
  import edram_tp_pkg::*;
#(
  parameter int N_MACROS = 3,
  parameter int BUS_W    = 18,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int SEL_W   = (N_MACROS > 1) ? $clog2(N_MACROS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tm_i,
  input  logic [4:0]          cmd_i,
  input  logic [BUS_W-1:0]    bus_i,
  input  logic                pg_valid_i,
  input  logic [1:0]          pg_op_i,
  input  logic [ADDR_W-1:0]   pg_addr_i,
  input  logic [DATA_W-1:0]   pg_wdata_i,
  output logic [SEL_W-1:0]    sel_o,
  output logic                bi_o,
  output logic [N_MACROS-1:0] en_o,
  output logic [1:0]          op_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o
);
  localparam logic [SEL_W:0] N_L = N_MACROS[SEL_W:0];

  logic [SEL_W-1:0]    sel_q;
  logic                bi_q;
  logic                row_ok_q;
  logic [ROW_W-1:0]    row_q;
  logic [DATA_W-1:0]   wd_hold_q;
  logic [N_MACROS-1:0] en_q;
  mac_op_e             op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [N_MACROS-1:0] sel_hot;
  logic [SEL_W-1:0]    idx;
  logic                is_rw;

  for (genvar i = 0; i < N_MACROS; i++) begin : g_hot
    assign sel_hot[i] = (sel_q == SEL_W'(i));
  end

  assign idx   = bus_i[SEL_W-1:0];
  assign is_rw = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      bi_q      <= 1'b0;
      row_ok_q  <= 1'b0;
      row_q     <= '0;
      wd_hold_q <= '0;
      en_q      <= '0;
      op_q      <= OP_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      en_q <= '0;
      op_q <= OP_IDLE;
      if (!tm_i) begin
        bi_q     <= 1'b0;
        row_ok_q <= 1'b0;
      end else if (bi_q) begin
        if (cmd_i == CMD_BI_OFF) begin
          bi_q <= 1'b0;
        end else if (pg_valid_i) begin
          en_q    <= sel_hot;
          op_q    <= mac_op_e'(pg_op_i);
          addr_q  <= pg_addr_i;
          wdata_q <= pg_wdata_i;
        end
      end else begin
        case (cmd_i)
          CMD_ROW: begin
            row_q    <= bus_i[ROW_W-1:0];
            row_ok_q <= 1'b1;
          end
          CMD_WDAT: wd_hold_q <= bus_i[DATA_W-1:0];
          CMD_RD, CMD_WR: begin
            if (row_ok_q) begin
              en_q     <= sel_hot;
              op_q     <= (cmd_i == CMD_RD) ? OP_READ : OP_WRITE;
              addr_q   <= {row_q, bus_i[COL_W-1:0]};
              wdata_q  <= wd_hold_q;
              row_ok_q <= 1'b0;
            end
          end
          CMD_SEL: if ({1'b0, idx} < N_L) sel_q <= idx;
          CMD_BI_ON: bi_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign sel_o   = sel_q;
  assign bi_o    = bi_q;
  assign en_o    = en_q;
  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  assert_idle_out_of_test_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tm_i |=> (en_o == '0 && !bi_o));
  assert_need_row_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_i && !bi_q && is_rw && !row_ok_q) |=> (en_o == '0));
  assert_sel_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, sel_o} < N_L));
  assert_single_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_o));
  assert_burnin_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_i && bi_q && cmd_i != CMD_BI_OFF && pg_valid_i) |=> (addr_o == $past(pg_addr_i)));
  assert_burnin_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bi_q && tm_i && cmd_i == CMD_BI_OFF) |=> !bi_o);
endmodule

// File: rtl/edram_tp_readmux.sv
module edram_tp_readmux #(
  parameter int                  N_MACROS = 3,
  parameter int                  DATA_W   = 8,
  parameter logic [N_MACROS-1:0] PAR_MASK = '1,
  localparam int WORD_W = DATA_W + 1,
  localparam int SEL_W  = (N_MACROS > 1) ? $clog2(N_MACROS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tm_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [N_MACROS*WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0]          dout_o
);
  logic [WORD_W-1:0]   word [N_MACROS];
  logic [N_MACROS-1:0] sel_hot;
  logic                sel_gen_par;

  for (genvar i = 0; i < N_MACROS; i++) begin : g_word
    logic [WORD_W-1:0] raw;
    assign raw        = rdata_i[i*WORD_W +: WORD_W];
    assign sel_hot[i] = (sel_i == SEL_W'(i));
    if (PAR_MASK[i]) begin : g_own_par
      assign word[i] = raw;
    end else begin : g_gen_par
      assign word[i] = {^raw[DATA_W-1:0], raw[DATA_W-1:0]};
    end
  end

  always_comb begin
    dout_o      = '0;
    sel_gen_par = 1'b0;
    for (int i = 0; i < N_MACROS; i++) begin
      if (sel_hot[i]) begin
        sel_gen_par = !PAR_MASK[i];
        if (tm_i) dout_o = word[i];
      end
    end
  end

  assert_even_parity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_i && sel_gen_par) |-> (^dout_o == 1'b0));
  assert_gated_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tm_i |-> (dout_o == '0));
endmodule

// File: rtl/edram_test_port.sv
module edram_test_port #(
  parameter int                  N_MACROS = 3,
  parameter int                  BUS_W    = 18,
  parameter int                  ROW_W    = 12,
  parameter int                  COL_W    = 10,
  parameter int                  DATA_W   = 8,
  parameter logic [N_MACROS-1:0] PAR_MASK = 3'b101,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int WORD_W = DATA_W + 1,
  localparam int SEL_W  = (N_MACROS > 1) ? $clog2(N_MACROS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tm_en_i,
  input  logic [4:0]                 cmd_i,
  input  logic [BUS_W-1:0]           bus_i,
  input  logic [N_MACROS*WORD_W-1:0] mac_rdata_i,
  input  logic                       pg_valid_i,
  input  logic [1:0]                 pg_op_i,
  input  logic [ADDR_W-1:0]          pg_addr_i,
  input  logic [DATA_W-1:0]          pg_wdata_i,
  output logic [WORD_W-1:0]          dout_o,
  output logic [N_MACROS-1:0]        mac_en_o,
  output logic [1:0]                 mac_op_o,
  output logic [ADDR_W-1:0]          mac_addr_o,
  output logic [DATA_W-1:0]          mac_wdata_o,
  output logic                       pg_en_o
);
  logic             tm_q;
  logic [4:0]       cmd_q;
  logic [BUS_W-1:0] bus_q;
  logic [SEL_W-1:0] sel;

  edram_tp_capture #(.CMD_W(5), .BUS_W(BUS_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tm_en_i (tm_en_i),
    .cmd_i   (cmd_i),
    .bus_i   (bus_i),
    .tm_o    (tm_q),
    .cmd_o   (cmd_q),
    .bus_o   (bus_q)
  );

  edram_tp_decode #(
    .N_MACROS (N_MACROS),
    .BUS_W    (BUS_W),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DATA_W   (DATA_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tm_i       (tm_q),
    .cmd_i      (cmd_q),
    .bus_i      (bus_q),
    .pg_valid_i (pg_valid_i),
    .pg_op_i    (pg_op_i),
    .pg_addr_i  (pg_addr_i),
    .pg_wdata_i (pg_wdata_i),
    .sel_o      (sel),
    .bi_o       (pg_en_o),
    .en_o       (mac_en_o),
    .op_o       (mac_op_o),
    .addr_o     (mac_addr_o),
    .wdata_o    (mac_wdata_o)
  );

  edram_tp_readmux #(
    .N_MACROS (N_MACROS),
    .DATA_W   (DATA_W),
    .PAR_MASK (PAR_MASK)
  ) u_rmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tm_i    (tm_q),
    .sel_i   (sel),
    .rdata_i (mac_rdata_i),
    .dout_o  (dout_o)
  );
endmodule

// File: tb/edram_test_port_tb_top.sv
`timescale 1ns/1ps
module edram_test_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tm_en = 1'b0;
  logic [4:0]  cmd = 5'h00;
  logic [17:0] bus = '0;
  logic [26:0] rdata;
  logic        pg_valid = 1'b0;
  logic [1:0]  pg_op = 2'd0;
  logic [21:0] pg_addr = '0;
  logic [7:0]  pg_wdata = '0;
  logic [8:0]  dout;
  logic [2:0]  mac_en;
  logic [1:0]  mac_op;
  logic [21:0] mac_addr;
  logic [7:0]  mac_wdata;
  logic        pg_en;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // macro 2: supplied parity 0; macro 1: supplied bit wrong, computed 1; macro 0: supplied 1
  assign rdata = {9'h03C, 9'h007, 9'h1A5};

  edram_test_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tm_en_i(tm_en), .cmd_i(cmd), .bus_i(bus),
    .mac_rdata_i(rdata), .pg_valid_i(pg_valid), .pg_op_i(pg_op),
    .pg_addr_i(pg_addr), .pg_wdata_i(pg_wdata), .dout_o(dout),
    .mac_en_o(mac_en), .mac_op_o(mac_op), .mac_addr_o(mac_addr),
    .mac_wdata_o(mac_wdata), .pg_en_o(pg_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] c, input logic [17:0] b);
    cmd = c;
    bus = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 enables", 32'(mac_en), 0);
    chk("R1 op", 32'(mac_op), 0);
    chk("R1 pg_en", 32'(pg_en), 0);
    chk("R1 dout", 32'(dout), 0);
  endtask

  task automatic t_gate;
    tm_en = 1'b0;
    send(5'h01, 18'h00ABC);
    chk("R2 en quiet", 32'(mac_en), 0);
    send(5'h03, 18'h00001);
    chk("R2 en quiet", 32'(mac_en), 0);
    send(5'h08, 18'h00002);
    chk("R2 en quiet", 32'(mac_en), 0);
    chk("R2 dout zero", 32'(dout), 0);
    send(5'h10, 18'h0);
    send(5'h00, 18'h0);
    chk("R2 no burn-in", 32'(pg_en), 0);
    tm_en = 1'b1;
    send(5'h00, 18'h0);
    send(5'h00, 18'h0);
    chk("R2 sel unchanged R1 macro0", 32'(dout), 32'h1A5);
  endtask

  task automatic t_read;
    send(5'h01, 18'h00ABC);
    send(5'h03, 18'h3F155);
    chk("R3 pre-issue idle", 32'(mac_en), 0);
    send(5'h00, 18'h0);
    chk("R3 en", 32'(mac_en), 32'h1);
    chk("R3 op read", 32'(mac_op), 1);
    chk("R3 addr", 32'(mac_addr), {10'h0, 12'hABC, 10'h155});
    send(5'h00, 18'h0);
    chk("R3 single cycle", 32'(mac_en), 0);
  endtask

  task automatic t_norow;
    send(5'h03, 18'h00001);
    send(5'h00, 18'h0);
    chk("R4 consumed row", 32'(mac_en), 0);
    send(5'h04, 18'h00002);
    send(5'h00, 18'h0);
    chk("R4 write no row", 32'(mac_en), 0);
  endtask

  task automatic t_write;
    send(5'h02, 18'h3FF5A);
    send(5'h01, 18'h00123);
    send(5'h04, 18'h003FF);
    send(5'h00, 18'h0);
    chk("R5 en", 32'(mac_en), 32'h1);
    chk("R5 op write", 32'(mac_op), 2);
    chk("R5 addr", 32'(mac_addr), {10'h0, 12'h123, 10'h3FF});
    chk("R5 wdata", 32'(mac_wdata), 32'h5A);
  endtask

  task automatic t_sel;
    send(5'h08, 18'h00001);
    send(5'h00, 18'h0);
    chk("R8 computed parity macro1", 32'(dout), 32'h107);
    send(5'h01, 18'h00005);
    send(5'h03, 18'h00006);
    send(5'h00, 18'h0);
    chk("R7 only macro1", 32'(mac_en), 32'h2);
    send(5'h08, 18'h00003);
    send(5'h00, 18'h0);
    chk("R6 index 3 ignored", 32'(dout), 32'h107);
    send(5'h08, 18'h00002);
    send(5'h00, 18'h0);
    chk("R8 own parity macro2", 32'(dout), 32'h03C);
  endtask

  task automatic t_burn;
    send(5'h10, 18'h0);
    send(5'h00, 18'h0);
    chk("R9 pg_en", 32'(pg_en), 1);
    pg_valid = 1'b1; pg_op = 2'd2; pg_addr = 22'h2ABCDE; pg_wdata = 8'hC3;
    send(5'h00, 18'h0);
    chk("R9 gen en", 32'(mac_en), 32'h4);
    chk("R9 gen op", 32'(mac_op), 2);
    chk("R9 gen addr", 32'(mac_addr), 32'h2ABCDE);
    chk("R9 gen wdata", 32'(mac_wdata), 32'hC3);
    pg_valid = 1'b0;
    send(5'h01, 18'h00111);
    send(5'h03, 18'h00001);
    chk("R9 ext ignored", 32'(mac_en), 0);
    send(5'h08, 18'h00000);
    send(5'h00, 18'h0);
    chk("R9 ext ignored", 32'(mac_en), 0);
    chk("R9 sel ignored", 32'(dout), 32'h03C);
    send(5'h11, 18'h0);
    send(5'h00, 18'h0);
    chk("R10 burn-in off", 32'(pg_en), 0);
    send(5'h03, 18'h00001);
    send(5'h00, 18'h0);
    chk("R9 row in burn-in ignored", 32'(mac_en), 0);
  endtask

  task automatic t_exit;
    send(5'h01, 18'h00777);
    tm_en = 1'b0;
    send(5'h00, 18'h0);
    tm_en = 1'b1;
    send(5'h03, 18'h00001);
    send(5'h00, 18'h0);
    chk("R10 row discarded", 32'(mac_en), 0);
    send(5'h10, 18'h0);
    tm_en = 1'b0;
    send(5'h00, 18'h0);
    send(5'h00, 18'h0);
    chk("R10 tm drop ends burn-in", 32'(pg_en), 0);
    tm_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_gate();
    t_read();
    t_norow();
    t_write();
    t_sel();
    t_burn();
    t_exit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule